// File: doc/BRIEF.md
# Auto-Reload Interval Timer with Event Counter

The block paces a stream of events from a programmable interval. A rising edge on the `arm` input captures `reload_val` both into a held reload register and into a down-counter. The down-counter steps down by one per clock. When it reaches zero it refills from the held value, so the interval repeats with no further action from the user. While the count is zero, `tick` is high for that single cycle. With a reload value N, one tick arrives every N+1 clocks.

A second counter adds one to `events` on every tick cycle. It wraps at its width and can be cleared synchronously. Holding `arm` high does not reload the timer again, so a value can be set up once and left running. New values on `reload_val` have no effect until the next rising edge of `arm`. All logic is on one clock with synchronous reset.

Top module: `reload_rate_counter`

## Requirements
- R1: A reload happens only in the cycle after a low-to-high change of `arm`. Keeping `arm` high never starts a second reload.
- R2: A reload sets both the down-counter and the held reload value to `reload_val`. Changes on `reload_val` without a rising `arm` edge leave the tick period unchanged.
- R3: When the count is zero and no reload is taking place, the next count is the held reload value.
- R4: Otherwise, without a reload, the count drops by one per clock.
- R5: `tick` is high exactly while the down-counter is zero. It is combinational from the count.
- R6: During reset, the down-counter and the held value become all ones, so `tick` is 0, and `events` becomes 0.
- R7: `clr` high forces `events` to 0 on the next clock. This takes priority over counting, even in a tick cycle.
- R8: Without `clr`, `events` adds one after each cycle in which `tick` is high, and holds otherwise.
- R9: With reload value N, ticks repeat every N+1 clocks. N=0 gives a tick on every clock.
- R10: The `arm` edge detector clears on reset. An `arm` held high through reset therefore causes one reload in the first clock after release.
- R11: `events` wraps modulo 2^WIDTH.
- R12: A rising edge on `arm` in the middle of a count takes priority over both the decrement and the zero-refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Rising edge loads a new interval |
| reload_val | input | WIDTH | Interval value taken on an arm edge |
| clr | input | 1 | Synchronous clear of the event count |
| tick | output | 1 | High while the down-counter is zero |
| events | output | WIDTH | Number of ticks seen since reset or clear |

## Verification
The embedded assertions check on every cycle that reload, refill, decrement, hold stability, clear priority and event increments step correctly from the previous cycle. Some properties span many cycles or depend on reset: the N+1 period, the immunity of a level-held `arm`, the single reload after reset with `arm` high, and the wrap of `events` at 2^WIDTH. Only the bench scenarios show these, checked against a behavioural model on every clock.

// File: rtl/reload_rate_counter.sv
module reload_rate_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [WIDTH-1:0] reload_val,
  input  logic             clr,
  output logic             tick,
  output logic [WIDTH-1:0] events
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO     = '0;
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             arm_q;
  logic             load;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] held;

  assign load = arm & ~arm_q;
  assign tick = (cnt == ZERO);

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= arm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= ALL_ONES;
      held <= ALL_ONES;
    end else if (load) begin
      cnt  <= reload_val;
      held <= reload_val;
    end else if (tick) begin
      cnt  <= held;
    end else begin
      cnt  <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       events <= ZERO;
    else if (clr)  events <= ZERO;
    else if (tick) events <= events + ONE;
  end

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
  a_r2_load_takes_value: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(reload_val)) && (held == $past(reload_val)));
  a_r2_held_stable: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(held));
  a_r3_zero_refill: assert property (@(posedge clk) disable iff (rst)
    (!load && tick) |=> cnt == $past(held));
  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> cnt == $past(cnt) - ONE);
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> events == ZERO);
  a_r8_count_up: assert property (@(posedge clk) disable iff (rst)
    (!clr && tick) |=> events == $past(events) + ONE);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick) |=> $stable(events));

endmodule

// File: tb/reload_rate_counter_test.sv
`timescale 1ns/1ps
module reload_rate_counter_test;
  localparam int W = 8;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic clr = 1'b0;
  logic [W-1:0] reload_val = '0;
  logic tick;
  logic [W-1:0] events;

  int vectors = 0;
  int errors = 0;
  int ticks_seen = 0;
  int m_cnt, m_hold, m_evt, old_cnt;
  bit m_prev, ld;

  always #2.5 clk = ~clk;

  reload_rate_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .arm(arm), .reload_val(reload_val),
    .clr(clr), .tick(tick), .events(events)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = MOD - 1; m_hold = MOD - 1; m_evt = 0; m_prev = 1'b0;
    end else begin
      ld = arm && !m_prev;
      m_prev = arm;
      old_cnt = m_cnt;
      if (ld) begin m_cnt = reload_val; m_hold = reload_val; end
      else if (m_cnt == 0) m_cnt = m_hold;
      else m_cnt = m_cnt - 1;
      if (clr) m_evt = 0;
      else if (old_cnt == 0) m_evt = (m_evt + 1) % MOD;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (tick) ticks_seen++;
      if (tick !== (m_cnt == 0)) begin
        errors++;
        $display("FAIL R5 tick actual=%0b expected=%0b", tick, m_cnt == 0);
      end
      if (events !== W'(m_evt)) begin
        errors++;
        $display("FAIL R8 events actual=%0d expected=%0d", events, m_evt);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    arm = 1'b1; reload_val = 8'd3;
    step(3);
    chk(events, 0, "R6 events at reset");
    chk(tick, 0, "R6 tick at reset");
    rst = 1'b0;
    step(3);
    chk(tick, 0, "R10 count not yet zero");
    step(1);
    chk(tick, 1, "R10 one reload after reset");
    ticks_seen = 0;
    step(40);
    chk(ticks_seen, 10, "R9 period N+1 with arm held (R1)");
    while (!tick) step(1);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    chk(events, 0, "R7 clear beats tick");
    arm = 1'b0; reload_val = 8'd0;
    ticks_seen = 0;
    step(20);
    chk(ticks_seen, 5, "R2 value ignored without edge");
    arm = 1'b1;
    step(1);
    chk(tick, 1, "R2 load of zero");
    ticks_seen = 0;
    step(10);
    chk(ticks_seen, 10, "R3 refill from zero hold, R9 N=0");
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    step(261);
    chk(events, 5, "R11 wrap modulo 2^W");
    arm = 1'b0;
    step(1);
    reload_val = 8'd9; arm = 1'b1;
    step(1);
    chk(tick, 0, "R4 loaded nine");
    step(8);
    chk(tick, 0, "R4 still counting");
    step(1);
    chk(tick, 1, "R4 reached zero after nine");
    arm = 1'b0;
    step(3);
    reload_val = 8'd2; arm = 1'b1;
    step(2);
    chk(tick, 0, "R12 mid-count load");
    step(1);
    chk(tick, 1, "R12 load overrode decrement");
    step(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule